// File: doc/BRIEF.md
# Scanned Key Matrix Encoder

This block controls a switch matrix of ROWS by COLS keys. It drives one row at a time, waits a fixed number of settle cycles, and samples the column inputs. It keeps a debounced pressed/released state for every key. Each accepted press becomes a key code built from the row index and the column index. The codes leave the block on a valid/ready stream.

Two rollover policies are available. With first-key lockout, the first reported key blocks every other press until the whole matrix is released. With queued n-key rollover, every overlapping press is captured and emitted in the order it was accepted. A small FIFO holds the codes until the consumer takes them. When the FIFO is full, further presses are dropped and a sticky overflow flag is raised.

Top module: `keyscan_encoder`

## Requirements
- R1: `row_sel` is one-hot. Bit i high drives row i. After reset row 0 is driven. Each row stays driven for SETTLE cycles, then the scan moves to the next row, and row ROWS-1 wraps to row 0. The scan may stay longer on a row only while earlier events are still being queued.
- R2: When column input bit j is high while row r is driven, key (r, j) reads as pressed. Its code carries r in the upper bits and j in the lower clog2(COLS) bits, so with COLS=4 the code is r*4+j.
- R3: A key's accepted state changes only after DEB consecutive samples of that key all disagree with the current state. A pulse that lasts fewer scans than this produces no code.
- R4: Only presses produce codes. Releasing a key emits nothing.
- R5: With `mode_in`=0 (first-key lockout), after a key is reported every other press is discarded until all keys are released. If several keys in one row are accepted in the same scan, only the lowest column is reported.
- R6: With `mode_in`=1 (n-key rollover), overlapping presses are all reported, one code per key, in the order they were accepted.
- R7: With `mode_in`=1, keys of one row accepted in the same scan are emitted in ascending column order.
- R8: The FIFO holds DEPTH codes. A press that finds the FIFO full is dropped and sets `overflow`. `overflow` stays high until reset.
- R9: While `key_valid` is high and `key_ready` is low, `key_valid` stays high and `key_code` stays unchanged. A code is removed on a cycle where both are high.
- R10: `mode_in` takes effect only in a cycle where no key is held in the debounced state. A change made while a key is held is ignored until all keys are released.
- R11: Reset clears the queue (`key_valid`=0), clears `overflow`, and selects row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_in | input | 1 | Rollover policy: 0 first-key lockout, 1 n-key queue |
| col_in | input | COLS | Column sense lines, high = switch closed on the driven row |
| row_sel | output | ROWS | One-hot row drive |
| key_valid | output | 1 | A key code is available |
| key_ready | input | 1 | Consumer accepts the code |
| key_code | output | clog2(ROWS)+clog2(COLS) | Row index (upper) and column index (lower) |
| overflow | output | 1 | Sticky flag: a press was dropped because the FIFO was full |

## Verification
The assertions check the following on every cycle:
- the row drive changes only at a sampling strobe;
- debounced state moves only at a sampling strobe;
- lockout mode never queues more than one pending column;
- the FIFO is never written while full;
- the overflow flag is sticky;
- the output code is held under backpressure;
- the policy register stays frozen while any key is held.

Some behaviour can only be shown by the bench's scenarios. These are:
- the code value produced for every key of the matrix;
- the suppression of short bounce pulses;
- the ordering of overlapping and same-row presses;
- the discarding of later keys under lockout;
- the exact point at which presses start to be dropped.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
    typedef enum logic {
        ROLL_FIRST = 1'b0,
        ROLL_QUEUE = 1'b1
    } roll_mode_e;
endpackage

// File: rtl/keyscan_row_scan.sv
module keyscan_row_scan #(
    parameter int ROWS   = 4,
    parameter int SETTLE = 2,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SW    = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    output logic [RW-1:0]   row_idx,
    output logic [ROWS-1:0] row_sel,
    output logic            sample_stb
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [SW-1:0] cnt;
    } scan_t;

    scan_t st_d, st_q;
    logic  at_end;

    always_comb begin
        st_d       = st_q;
        at_end     = (st_q.cnt == SW'(SETTLE - 1));
        sample_stb = at_end && !hold;
        if (!at_end) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (!hold) begin
            st_d.cnt = '0;
            st_d.row = (st_q.row == RW'(ROWS - 1)) ? '0 : st_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_idx = st_q.row;

    for (genvar i = 0; i < ROWS; i++) begin : g_rowdec
        assign row_sel[i] = (st_q.row == RW'(i));
    end

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(row_sel)); // R1
endmodule

// File: rtl/keyscan_debounce.sv
module keyscan_debounce #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DEB  = 2,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int DW  = (DEB > 1) ? $clog2(DEB) : 1,
    localparam int NK  = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_stb,
    input  logic [RW-1:0]   row_idx,
    input  logic [COLS-1:0] col_in,
    output logic [COLS-1:0] press_ev,
    output logic            any_held
);
    typedef struct packed {
        logic [NK-1:0]         stable;
        logic [NK-1:0][DW-1:0] cnt;
    } deb_t;

    deb_t st_d, st_q;
    int   k;

    always_comb begin
        st_d     = st_q;
        press_ev = '0;
        k        = 0;
        if (sample_stb) begin
            for (int c = 0; c < COLS; c++) begin
                k = int'(row_idx) * COLS + c;
                if (col_in[c] != st_q.stable[k]) begin
                    if (st_q.cnt[k] == DW'(DEB - 1)) begin
                        st_d.stable[k] = col_in[c];
                        st_d.cnt[k]    = '0;
                        press_ev[c]    = col_in[c];
                    end else begin
                        st_d.cnt[k] = st_q.cnt[k] + 1'b1;
                    end
                end else begin
                    st_d.cnt[k] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign any_held = |st_q.stable;

    AST_STATE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(any_held)); // R3
endmodule

// File: rtl/keyscan_fifo.sv
module keyscan_fifo #(
    parameter int W     = 4,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int NW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wptr;
        logic [AW-1:0]           rptr;
        logic [NW-1:0]           num;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  pop;

    always_comb begin
        st_d = st_q;
        pop  = rd_valid && rd_ready;
        if (wr_en) begin
            st_d.mem[st_q.wptr] = wr_data;
            st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop) begin
            st_d.rptr = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
        end
        st_d.num = st_q.num + NW'(wr_en) - NW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full     = (st_q.num == NW'(DEPTH));
    assign rd_valid = (st_q.num != '0);
    assign rd_data  = st_q.mem[st_q.rptr];

    AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R8
    AST_HOLD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R9
endmodule

// File: rtl/keyscan_encoder.sv
module keyscan_encoder
    import keyscan_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int COLS   = 4,
    parameter int SETTLE = 2,
    parameter int DEB    = 2,
    parameter int DEPTH  = 4,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int CODEW = RW + CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_in,
    input  logic [COLS-1:0]  col_in,
    output logic [ROWS-1:0]  row_sel,
    output logic             key_valid,
    input  logic             key_ready,
    output logic [CODEW-1:0] key_code,
    output logic             overflow
);
    typedef struct packed {
        logic [COLS-1:0] pend;
        logic [RW-1:0]   pend_row;
        roll_mode_e      mode;
        logic            lock;
        logic            ovf;
    } ctl_t;

    ctl_t             st_d, st_q;
    logic [RW-1:0]    row_idx;
    logic             sample_stb;
    logic [COLS-1:0]  press_ev;
    logic             any_held;
    logic             fifo_full;
    logic             push;
    logic [CODEW-1:0] push_code;
    logic [CW-1:0]    low_col;

    keyscan_row_scan #(.ROWS(ROWS), .SETTLE(SETTLE)) scan_i (
        .clk(clk), .rst_n(rst_n), .hold(|st_q.pend),
        .row_idx(row_idx), .row_sel(row_sel), .sample_stb(sample_stb)
    );

    keyscan_debounce #(.ROWS(ROWS), .COLS(COLS), .DEB(DEB)) deb_i (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .row_idx(row_idx),
        .col_in(col_in), .press_ev(press_ev), .any_held(any_held)
    );

    keyscan_fifo #(.W(CODEW), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_code),
        .full(fifo_full), .rd_valid(key_valid), .rd_ready(key_ready),
        .rd_data(key_code)
    );

    always_comb begin
        low_col = '0;
        for (int j = COLS - 1; j >= 0; j--) begin
            if (st_q.pend[j]) low_col = CW'(j);
        end
    end

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        push_code = {st_q.pend_row, low_col};
        if (!any_held) begin
            st_d.mode = roll_mode_e'(mode_in);
            if (st_q.pend == '0) st_d.lock = 1'b0;
        end
        if (sample_stb && (press_ev != '0)) begin
            if (st_q.mode == ROLL_QUEUE) begin
                st_d.pend     = press_ev;
                st_d.pend_row = row_idx;
            end else if (!st_q.lock) begin
                st_d.pend     = press_ev & (~press_ev + COLS'(1));
                st_d.pend_row = row_idx;
                st_d.lock     = 1'b1;
            end
        end else if (st_q.pend != '0) begin
            st_d.pend[low_col] = 1'b0;
            if (fifo_full) st_d.ovf = 1'b1;
            else           push     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pend: '0, pend_row: '0, mode: ROLL_FIRST, lock: 1'b0, ovf: 1'b0};
        else        st_q <= st_d;
    end

    assign overflow = st_q.ovf;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R8
    AST_LOCKOUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == ROLL_FIRST) |-> ($countones(st_q.pend) <= 1)); // R5
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        any_held |=> $stable(st_q.mode)); // R10
endmodule

// File: tb/keyscan_encoder_tb_top.sv
module keyscan_encoder_tb_top;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int SETTLE = 2;
    localparam int NK = ROWS * COLS;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_in = 1'b1;
    logic [COLS-1:0] col_in;
    logic [ROWS-1:0] row_sel;
    logic            key_valid;
    logic            key_ready = 1'b0;
    logic [3:0]      key_code;
    logic            overflow;
    logic [NK-1:0]   keys = '0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    keyscan_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .col_in(col_in),
        .row_sel(row_sel), .key_valid(key_valid), .key_ready(key_ready),
        .key_code(key_code), .overflow(overflow)
    );

    always_comb begin
        col_in = '0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                if (row_sel[r] && keys[r*COLS+c]) col_in[c] = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_code(input int exp, input string req);
        int t = 0;
        while (!key_valid && t < 300) begin
            @(negedge clk);
            t++;
        end
        check(key_valid && key_code == 4'(exp), req, key_valid ? int'(key_code) : -1, exp);
        if (key_valid) begin
            key_ready = 1'b1;
            @(negedge clk);
            key_ready = 1'b0;
        end
    endtask

    task automatic expect_none(input int n, input string req);
        cyc(n);
        check(!key_valid, req, key_valid ? int'(key_code) : -1, -1);
    endtask

    task automatic release_all();
        keys = '0;
        cyc(100);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        // R11 reset state and R1 scan order
        check(row_sel == 4'b0001 && !key_valid && !overflow, "R11", int'(row_sel), 1);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            check(row_sel == 4'(1 << ((k / SETTLE) % ROWS)), "R1", int'(row_sel),
                  1 << ((k / SETTLE) % ROWS));
        end

        // R2 / R4: every key alone, n-key mode; release gives no code
        mode_in = 1'b1;
        for (int k = 0; k < NK; k++) begin
            keys[k] = 1'b1;
            expect_code((k / COLS) * 4 + (k % COLS), "R2");
            keys = '0;
            expect_none(100, "R4");
        end

        // R6: overlapping presses in press order
        keys[5] = 1'b1; cyc(40); keys[14] = 1'b1;
        expect_code(5, "R6"); expect_code(14, "R6");
        release_all();
        keys[9] = 1'b1; cyc(40); keys[2] = 1'b1;
        expect_code(9, "R6"); expect_code(2, "R6");
        release_all();

        // R7: same row, same scan, ascending columns
        keys[13] = 1'b1; keys[12] = 1'b1;
        expect_code(12, "R7"); expect_code(13, "R7");
        release_all();
        keys[11] = 1'b1; keys[8] = 1'b1;
        expect_code(8, "R7"); expect_code(11, "R7");
        release_all();

        // R5: first-key lockout
        mode_in = 1'b0; cyc(10);
        keys[6] = 1'b1; cyc(40); keys[3] = 1'b1;
        expect_code(6, "R5");
        expect_none(100, "R5");
        keys[6] = 1'b0;
        expect_none(100, "R5");
        release_all();
        keys[3] = 1'b1;
        expect_code(3, "R5");
        release_all();
        keys[1] = 1'b1; keys[2] = 1'b1;
        expect_code(1, "R5");
        expect_none(100, "R5");
        release_all();

        // R10: policy change ignored while a key is held
        keys[0] = 1'b1;
        expect_code(0, "R10");
        mode_in = 1'b1; cyc(20);
        keys[7] = 1'b1;
        expect_none(100, "R10");
        release_all();
        keys[4] = 1'b1; cyc(40); keys[7] = 1'b1;
        expect_code(4, "R10"); expect_code(7, "R10");
        release_all();

        // R3: pulses shorter than the debounce span give nothing
        for (int p = 0; p < 5; p++) begin
            keys[10] = 1'b1; cyc(ROWS * SETTLE);
            keys[10] = 1'b0; cyc(ROWS * SETTLE);
        end
        expect_none(100, "R3");

        // R8 / R9: fill queue with consumer stalled
        for (int k = 0; k < 6; k++) begin
            keys[k] = 1'b1; cyc(40);
            if (k == 3) check(!overflow, "R8", overflow, 0);
        end
        check(overflow, "R8", overflow, 1);
        check(key_valid && key_code == 4'd0, "R9", int'(key_code), 0);
        cyc(20);
        check(key_valid && key_code == 4'd0, "R9", int'(key_code), 0);
        for (int k = 0; k < 4; k++) expect_code(k, "R8");
        expect_none(20, "R8");
        check(overflow, "R8", overflow, 1);
        release_all();

        // R11: reset clears the sticky flag
        rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(1);
        check(!overflow && !key_valid, "R11", overflow, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule